// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup stage of a two-way set-associative cache. Every set carries a small prediction field naming the way expected to hit next. When a read is accepted, the predicted way's word is steered onto the output and only that way's tag is compared. If it matches, the read completes one cycle after acceptance as a fast hit. If it does not match, the block stalls its request side for one cycle and compares the tag of the other way. That second check produces a slow hit, and the predictor is retrained to the way that hit, or it produces a true miss that the miss path must service.

Lines are installed through a refill port. It writes a whole line, its tag and its valid bit into a chosen way, and it points the set's prediction at that way. Victim selection and the miss engine sit outside the block. Each response carries a two-bit status, so a requester knows both the outcome and the latency of every access.

Top module: `wp_lookup`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1, and every way of every set is invalid, so any lookup ends as a miss.
- R2: A read accepted (req_valid and req_ready at a clock edge) whose tag matches a valid line in the predicted way gives, after that same edge, resp_valid=1, resp_status=2'b01 (fast hit) and the addressed word on resp_data.
- R3: When the predicted way does not match but the other way holds a valid matching line, req_ready is 0 for one cycle. After the next edge the block gives resp_valid=1, resp_status=2'b10 (slow hit) and the word from the other way.
- R4: When neither way matches, req_ready is 0 for one cycle. After the next edge the block gives resp_valid=1, resp_status=2'b11 (miss) and resp_data=0.
- R5: After a slow hit, the set's prediction names the way that hit, so a following read of the same line is a fast hit.
- R6: A refill at a clock edge writes the line (word w at bits [32*w+31:32*w]), the tag and the valid bit into way refill_way of the set given by refill_addr, replacing the old contents. It also sets that set's prediction to refill_way.
- R7: A request presented while req_ready is 0 is ignored and produces no response.
- R8: Address decoding: bits [3:2] select the word within the line, bits [7:4] select the set, and bits [31:8] form the tag.
- R9: If a refill and a slow-hit retrain target the same set at the same edge, the refill's way is the one kept as the prediction.
- R10: resp_valid is a one-cycle pulse for each accepted read, and resp_status is 2'b00 whenever resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the read |
| req_ready | output | 1 | Request accepted at this edge when high |
| resp_valid | output | 1 | Response pulse |
| resp_status | output | 2 | 01 fast hit, 10 slow hit, 11 miss, 00 idle |
| resp_data | output | 32 | Word read (zero on miss) |
| refill_valid | input | 1 | Write a line at this edge |
| refill_addr | input | 32 | Address selecting set and tag of the line |
| refill_way | input | 1 | Way to write |
| refill_line | input | 128 | Line data, word 0 in the low bits |

## Verification
A fast hit is visible on the response one edge after acceptance. A slow hit or a miss is visible two edges after acceptance, and req_ready is low in the cycle between. The bench drives on falling edges and samples on the falling edge after each relevant rising edge. For a second-cycle result it first confirms that no response is present and that req_ready is low, and only then samples the response one cycle later. Retraining and refill effects are judged from the latency class that the next access reports. Ignored requests are judged by the absence of a response in the cycle where one would otherwise appear.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic [1:0] {
      ST_NONE = 2'b00,
      ST_FAST = 2'b01,
      ST_SLOW = 2'b10,
      ST_MISS = 2'b11
   } wp_status_e;

   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } wp_phase_e;

endpackage

// File: rtl/wp_arrays.sv
module wp_arrays #(
   parameter int WAYS  = 2,
   parameter int SETS  = 16,
   parameter int WORDS = 4,
   parameter int TAG_W = 24,
   parameter int DW    = 32,
   localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1,
   localparam int SET_W  = (SETS  > 1) ? $clog2(SETS)  : 1,
   localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [SET_W-1:0]            wr_set,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic [WORDS*DW-1:0]         wr_line,
   input  logic [SET_W-1:0]            rd_set,
   input  logic [WORD_W-1:0]           rd_word,
   output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
   output logic [WAYS-1:0]             rd_valid,
   output logic [WAYS-1:0][DW-1:0]     rd_data
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]    tag_q  [SETS];
      logic [WORDS*DW-1:0] line_q [SETS];
      logic [SETS-1:0]     vld_q;
      logic                hit_wr;

      assign hit_wr = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (hit_wr) begin
            vld_q[wr_set] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_wr) begin
            tag_q[wr_set]  <= wr_tag;
            line_q[wr_set] <= wr_line;
         end
      end

      assign rd_tag[w]   = tag_q[rd_set];
      assign rd_valid[w] = vld_q[rd_set];
      assign rd_data[w]  = line_q[rd_set][rd_word*DW +: DW];
   end

endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
   parameter int SETS  = 16,
   parameter int WAY_W = 1,
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAY_W-1:0] rd_way,
   input  logic             trn_en,
   input  logic [SET_W-1:0] trn_set,
   input  logic [WAY_W-1:0] trn_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way
);

   logic [WAY_W-1:0] pred_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) pred_q[s] <= '0;
      end else begin
         if (trn_en)  pred_q[trn_set]  <= trn_way;
         // a refill written later in the block takes precedence
         if (fill_en) pred_q[fill_set] <= fill_way;
      end
   end

   assign rd_way = pred_q[rd_set];

endmodule

// File: rtl/wp_tag_match.sv
module wp_tag_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 24,
   parameter int DW    = 32,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAY_W-1:0]           sel_way,
   input  logic [TAG_W-1:0]           look_tag,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            valids,
   input  logic [WAYS-1:0][DW-1:0]    words,
   output logic                       hit,
   output logic [DW-1:0]              word
);

   // one comparator, shared by both lookup cycles
   logic [TAG_W-1:0] sel_tag;

   assign sel_tag = tags[sel_way];
   assign word    = words[sel_way];
   assign hit     = valids[sel_way] && (sel_tag == look_tag);

endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
   import wp_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SETS       = 16,
   parameter int LINE_WORDS = 4,
   parameter int WAYS       = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [ADDR_W-1:0]            req_addr,
   output logic                         req_ready,
   output logic                         resp_valid,
   output logic [1:0]                   resp_status,
   output logic [DATA_W-1:0]            resp_data,
   input  logic                         refill_valid,
   input  logic [ADDR_W-1:0]            refill_addr,
   input  logic [$clog2(WAYS)-1:0]      refill_way,
   input  logic [LINE_WORDS*DATA_W-1:0] refill_line
);

   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORD_W = $clog2(LINE_WORDS);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TAG_LO = BYTE_W + WORD_W + SET_W;
   localparam int TAG_W  = ADDR_W - TAG_LO;

   if (WAYS != 2) begin : g_bad_ways
      $error("wp_lookup: the second-cycle check supports exactly two ways");
   end
   if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("wp_lookup: SETS must be a power of two, at least 2");
   end
   if ((LINE_WORDS < 2) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0)) begin : g_bad_words
      $error("wp_lookup: LINE_WORDS must be a power of two, at least 2");
   end
   if ((DATA_W < 8) || (DATA_W % 8 != 0) || (TAG_W < 1)) begin : g_bad_widths
      $error("wp_lookup: inconsistent address and data widths");
   end

   wp_phase_e          phase_q;
   logic [ADDR_W-1:0]  pend_addr_q;
   logic [WAY_W-1:0]   pend_way_q;

   logic [ADDR_W-1:0]  look_addr;
   logic [SET_W-1:0]   look_set;
   logic [WORD_W-1:0]  look_word;
   logic [TAG_W-1:0]   look_tag;
   logic [WAY_W-1:0]   pred_way;
   logic [WAY_W-1:0]   sel_way;
   logic               accept;
   logic               hit;
   logic [DATA_W-1:0]  hit_word;

   logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
   logic [WAYS-1:0]             rd_valid;
   logic [WAYS-1:0][DATA_W-1:0] rd_data;

   logic [SET_W-1:0]   fill_set;
   logic [TAG_W-1:0]   fill_tag;
   logic               trn_en;

   assign req_ready = (phase_q == PH_FIRST);
   assign accept    = req_valid && req_ready;

   assign look_addr = (phase_q == PH_SECOND) ? pend_addr_q : req_addr;
   assign look_word = look_addr[BYTE_W +: WORD_W];
   assign look_set  = look_addr[BYTE_W + WORD_W +: SET_W];
   assign look_tag  = look_addr[TAG_LO +: TAG_W];

   assign fill_set  = refill_addr[BYTE_W + WORD_W +: SET_W];
   assign fill_tag  = refill_addr[TAG_LO +: TAG_W];

   assign sel_way   = (phase_q == PH_SECOND) ? pend_way_q : pred_way;
   assign trn_en    = (phase_q == PH_SECOND) && hit;

   wp_arrays #(
      .WAYS  (WAYS),
      .SETS  (SETS),
      .WORDS (LINE_WORDS),
      .TAG_W (TAG_W),
      .DW    (DATA_W)
   ) u_arrays (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (refill_valid),
      .wr_way   (refill_way),
      .wr_set   (fill_set),
      .wr_tag   (fill_tag),
      .wr_line  (refill_line),
      .rd_set   (look_set),
      .rd_word  (look_word),
      .rd_tag   (rd_tag),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   wp_pred_table #(
      .SETS  (SETS),
      .WAY_W (WAY_W)
   ) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (look_set),
      .rd_way   (pred_way),
      .trn_en   (trn_en),
      .trn_set  (look_set),
      .trn_way  (pend_way_q),
      .fill_en  (refill_valid),
      .fill_set (fill_set),
      .fill_way (refill_way)
   );

   wp_tag_match #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .DW    (DATA_W)
   ) u_match (
      .sel_way  (sel_way),
      .look_tag (look_tag),
      .tags     (rd_tag),
      .valids   (rd_valid),
      .words    (rd_data),
      .hit      (hit),
      .word     (hit_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_FIRST;
         pend_addr_q <= '0;
         pend_way_q  <= '0;
         resp_valid  <= 1'b0;
         resp_status <= ST_NONE;
         resp_data   <= '0;
      end else begin
         resp_valid  <= 1'b0;
         resp_status <= ST_NONE;
         resp_data   <= '0;
         if (accept) begin
            if (hit) begin
               resp_valid  <= 1'b1;
               resp_status <= ST_FAST;
               resp_data   <= hit_word;
            end else begin
               phase_q     <= PH_SECOND;
               pend_addr_q <= req_addr;
               pend_way_q  <= ~pred_way;
            end
         end
         if (phase_q == PH_SECOND) begin
            phase_q    <= PH_FIRST;
            resp_valid <= 1'b1;
            if (hit) begin
               resp_status <= ST_SLOW;
               resp_data   <= hit_word;
            end else begin
               resp_status <= ST_MISS;
            end
         end
      end
   end

endmodule

// File: rtl/wp_lookup_chk.sv
module wp_lookup_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              resp_valid,
   input logic [1:0]        resp_status,
   input logic [DATA_W-1:0] resp_data
);

   a_r2_fast_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == 2'b01) |-> $past(req_valid && req_ready));

   a_r3_second_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status[1]) |-> $past(!req_ready));

   a_r4_miss_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == 2'b11) |-> (resp_data == '0));

   a_r7_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> req_ready);

   a_r10_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (resp_status == 2'b00));

   a_r10_valid_status: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_status != 2'b00));

endmodule

bind wp_lookup wp_lookup_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/wp_lookup_bench.sv
module wp_lookup_bench;

   localparam time CLK_P = 4ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         req_ready;
   logic         resp_valid;
   logic [1:0]   resp_status;
   logic [31:0]  resp_data;
   logic         refill_valid = 1'b0;
   logic [31:0]  refill_addr = '0;
   logic [0:0]   refill_way = '0;
   logic [127:0] refill_line = '0;

   int total = 0;
   int bad   = 0;

   always #(CLK_P / 2) clk = ~clk;

   wp_lookup u_wp_lookup (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .req_ready    (req_ready),
      .resp_valid   (resp_valid),
      .resp_status  (resp_status),
      .resp_data    (resp_data),
      .refill_valid (refill_valid),
      .refill_addr  (refill_addr),
      .refill_way   (refill_way),
      .refill_line  (refill_line)
   );

   localparam logic [1:0] FAST = 2'b01, SLOW = 2'b10, MISS = 2'b11;

   function automatic logic [31:0] mk_addr(input logic [7:0] tag, input logic [3:0] set,
                                           input logic [1:0] w);
      return {16'h0000, tag, set, w, 2'b00};
   endfunction

   function automatic logic [31:0] pat(input logic [7:0] tag, input int w);
      return {8'hC5, tag, 8'(w + 16), 8'h3A};
   endfunction

   function automatic logic [127:0] mk_line(input logic [7:0] tag);
      logic [127:0] l;
      for (int w = 0; w < 4; w++) l[w*32 +: 32] = pat(tag, w);
      return l;
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic refill(input logic [7:0] tag, input logic [3:0] set, input logic way);
      @(negedge clk);
      refill_valid = 1'b1;
      refill_addr  = mk_addr(tag, set, 2'd0);
      refill_way   = way;
      refill_line  = mk_line(tag);
      @(negedge clk);
      refill_valid = 1'b0;
   endtask

   task automatic lookup(input logic [7:0] tag, input logic [3:0] set, input logic [1:0] w,
                         input logic [1:0] exp_st, input string rq);
      logic [31:0] exp_d;
      exp_d = (exp_st == MISS) ? 32'h0 : pat(tag, int'(w));
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = mk_addr(tag, set, w);
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_st != FAST) begin
         check(!resp_valid && !req_ready, {rq, " stall"}, {resp_valid, req_ready}, 32'h0);
         @(negedge clk);
      end
      check(resp_valid && resp_status == exp_st, {rq, " status"},
            {resp_valid, resp_status}, {1'b1, exp_st});
      check(resp_data == exp_d, {rq, " data"}, resp_data, exp_d);
   endtask

   task automatic t_reset;
      check(!resp_valid && req_ready, "R1 idle after reset", {resp_valid, req_ready}, 32'h1);
      lookup(8'h01, 4'd0, 2'd0, MISS, "R1 empty miss");
      lookup(8'h00, 4'd15, 2'd3, MISS, "R1 empty miss zero tag");
   endtask

   task automatic t_fast_words;
      refill(8'h11, 4'd3, 1'b0);
      for (int w = 0; w < 4; w++) lookup(8'h11, 4'd3, 2'(w), FAST, "R2 R8 fast word");
   endtask

   task automatic t_slow_retrain;
      refill(8'h22, 4'd3, 1'b1);
      lookup(8'h22, 4'd3, 2'd1, FAST, "R6 refill predicts way1");
      lookup(8'h11, 4'd3, 2'd2, SLOW, "R3 slow hit way0");
      lookup(8'h11, 4'd3, 2'd0, FAST, "R5 retrained to way0");
      lookup(8'h22, 4'd3, 2'd3, SLOW, "R3 slow hit way1");
      lookup(8'h22, 4'd3, 2'd2, FAST, "R5 retrained to way1");
   endtask

   task automatic t_miss;
      lookup(8'h33, 4'd3, 2'd1, MISS, "R4 tag miss");
      lookup(8'h11, 4'd4, 2'd1, MISS, "R8 other set miss");
   endtask

   task automatic t_overwrite;
      refill(8'h44, 4'd3, 1'b0);
      lookup(8'h44, 4'd3, 2'd2, FAST, "R6 new line fast");
      lookup(8'h11, 4'd3, 2'd2, MISS, "R6 old line gone");
      lookup(8'h22, 4'd3, 2'd0, SLOW, "R6 other way kept");
   endtask

   task automatic t_ignore;
      refill(8'h91, 4'd9, 1'b1);
      refill(8'h90, 4'd9, 1'b0);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = mk_addr(8'h91, 4'd9, 2'd1);
      @(negedge clk);
      req_addr  = mk_addr(8'h90, 4'd9, 2'd0);
      check(!resp_valid && !req_ready, "R7 stalled", {resp_valid, req_ready}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
      check(resp_valid && resp_status == SLOW, "R7 slow response",
            {resp_valid, resp_status}, {1'b1, SLOW});
      check(resp_data == pat(8'h91, 1), "R7 slow data", resp_data, pat(8'h91, 1));
      @(negedge clk);
      check(!resp_valid, "R7 no response for ignored request", resp_valid, 32'h0);
      check(resp_status == 2'b00, "R10 idle status", resp_status, 32'h0);
   endtask

   task automatic t_conflict;
      refill(8'hB0, 4'd7, 1'b1);
      refill(8'hA0, 4'd7, 1'b0);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = mk_addr(8'hB0, 4'd7, 2'd2);
      @(negedge clk);
      req_valid    = 1'b0;
      refill_valid = 1'b1;
      refill_addr  = mk_addr(8'hC0, 4'd7, 2'd0);
      refill_way   = 1'b0;
      refill_line  = mk_line(8'hC0);
      check(!resp_valid && !req_ready, "R9 stall", {resp_valid, req_ready}, 32'h0);
      @(negedge clk);
      refill_valid = 1'b0;
      check(resp_valid && resp_status == SLOW, "R9 slow hit",
            {resp_valid, resp_status}, {1'b1, SLOW});
      check(resp_data == pat(8'hB0, 2), "R9 data", resp_data, pat(8'hB0, 2));
      lookup(8'hC0, 4'd7, 2'd1, FAST, "R9 refill way wins prediction");
      lookup(8'hA0, 4'd7, 2'd1, MISS, "R9 replaced line");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fast_words;
      t_slow_retrain;
      t_miss;
      t_overwrite;
      t_ignore;
      t_conflict;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule